// File: doc/BRIEF.md
# I2C Register Initialisation Sequencer

This block brings up an external clock device after power-on without any processor involvement. It steps through a short program held in an on-chip ROM, and every step talks to a byte-level I2C master through that master's small register bus. A step does one of three things. It writes a word into one of the master's registers. It polls a master register until that register shows an expected value. Or it ends the program. The bit-level I2C engine sits outside the block.

The ROM is filled at elaboration from parameters. First comes the master's timing setup. Then one transaction points an I2C bus switch at the wanted channel. After that, one three-byte transaction per device register loads the divider values and the two closing control writes. The sequencer stays parked at step zero while an external "device not ready" flag is high, and starts once the flag drops. When it reaches the end step it raises `done` and goes quiet.

Top module: `i2c_init_seq`

## Requirements
- R1: While `rst` or `dev_not_ready` is high, `bus_we` and `done` stay low. When both are low, execution begins again from program step zero.
- R2: The first bus write goes to the configuration register (address 0). Its data is `CLK_HZ/1000`, which is 50000 with the default parameters.
- R3: Every I2C transaction goes to the transfer register (address 1). It is a START command (data 16'h0200), then one WRITE command per byte (data 16'h0100 with the byte in bits 7:0), then a STOP command (data 16'h0400).
- R4: The first transaction carries two bytes. The first is the switch address shifted left by one with bit 0 clear (8'hE0 by default). The second has only bit `SW_CH` set (8'h80 by default).
- R5: Each later transaction carries the device address shifted left by one (8'hD2), then a register index, then a data byte. Each 24-bit divider is sent most significant byte first, to indices `DIV_BASE`, `DIV_BASE+1` and `DIV_BASE+2`, divider after divider.
- R6: The last two transactions write the fast-lock register (index 8'h60, data 8'h01) and then the calibration register (index 8'h61, data 8'h40), in that order.
- R7: A wait step keeps reading its register every cycle. It advances only when the read data equals the expected value (idle status 16'h0001 on the transfer register), with no time limit. So no command is written while the master is busy.
- R8: `bus_we` is high for exactly one cycle per write step, with `bus_addr` and `bus_wdata` valid in that cycle.
- R9: `done` rises only after all 45 bus writes of the default program. It then stays high and `bus_we` stays low until reset or `dev_not_ready`.
- R10: Raising `dev_not_ready` partway through a program aborts it. After the flag falls, the full write sequence is replayed from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_not_ready | input | 1 | Holds the sequencer at step zero while high |
| bus_addr | output | 2 | Master register address |
| bus_wdata | output | 16 | Master register write data |
| bus_we | output | 1 | Single-cycle write strobe |
| bus_rdata | input | 16 | Master register read data for the addressed register |
| done | output | 1 | Program finished |

## Verification
The bench models the master with a busy window of fixed length after each transfer command. The whole program runs with windows of zero, three and seventeen cycles. A zero window shows that a wait step passes straight through when the status is already idle. The longer windows show that no command ever overtakes a busy master, and that polling has no timeout. The write stream is compared in full against a list built arithmetically from the parameters. This catches wrong framing, byte order or closing order. A run cut short by `dev_not_ready` shows that the program restarts from its first step.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int REG_AW = 2;
  localparam int REG_DW = 16;

  // master register map
  localparam logic [REG_AW-1:0] CFG_REG  = 2'd0;
  localparam logic [REG_AW-1:0] XFER_REG = 2'd1;

  // transfer register command words
  localparam logic [REG_DW-1:0] CMD_WRITE = 16'h0100;
  localparam logic [REG_DW-1:0] CMD_START = 16'h0200;
  localparam logic [REG_DW-1:0] CMD_STOP  = 16'h0400;
  localparam logic [REG_DW-1:0] STAT_IDLE = 16'h0001;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_WAIT = 2'd1,
    OP_END  = 2'd2
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

endpackage

// File: rtl/i2c_seq_rom.sv
module i2c_seq_rom
  import i2c_seq_pkg::*;
#(
  parameter int          CLK_HZ   = 50_000_000,
  parameter logic [6:0]  SW_ADDR  = 7'h70,
  parameter int          SW_CH    = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int          NUM_DIV  = 2,
  parameter logic [NUM_DIV*24-1:0] DIV_VALS = {24'h00F3E4, 24'h0A1B2C},
  parameter logic [7:0]  DIV_BASE = 8'h20,
  parameter logic [7:0]  LOCK_REG = 8'h60,
  parameter logic [7:0]  LOCK_VAL = 8'h01,
  parameter logic [7:0]  CAL_REG  = 8'h61,
  parameter logic [7:0]  CAL_VAL  = 8'h40,
  localparam int NUM_DEV   = NUM_DIV * 3 + 2,
  localparam int NUM_TX    = NUM_DEV + 1,
  localparam int PROG_LEN  = 1 + 8 + NUM_DEV * 10 + 1,
  localparam int AW        = $clog2(PROG_LEN),
  localparam int MEM_DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output instr_t        rd_data
);

  instr_t mem [MEM_DEPTH];

  function automatic instr_t mk(op_e op, logic [REG_AW-1:0] a, logic [REG_DW-1:0] d);
    instr_t r;
    r.op   = op;
    r.addr = a;
    r.data = d;
    return r;
  endfunction

  function automatic int tx_len(int t);
    return (t == 0) ? 2 : 3;
  endfunction

  function automatic logic [7:0] dev_index(int e);
    if (e < NUM_DIV * 3)       return DIV_BASE + 8'(e);
    else if (e == NUM_DIV * 3) return LOCK_REG;
    else                       return CAL_REG;
  endfunction

  function automatic logic [7:0] dev_value(int e);
    if (e < NUM_DIV * 3)       return DIV_VALS[(e / 3) * 24 + 8 * (2 - (e % 3)) +: 8];
    else if (e == NUM_DIV * 3) return LOCK_VAL;
    else                       return CAL_VAL;
  endfunction

  function automatic logic [7:0] tx_byte(int t, int b);
    if (t == 0) begin
      if (b == 0) return {SW_ADDR, 1'b0};
      else        return 8'(1 << SW_CH);
    end else begin
      if (b == 0)      return {DEV_ADDR, 1'b0};
      else if (b == 1) return dev_index(t - 1);
      else             return dev_value(t - 1);
    end
  endfunction

  initial begin
    int p;
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = mk(OP_END, '0, '0);
    p = 0;
    mem[p] = mk(OP_WR, CFG_REG, REG_DW'(CLK_HZ / 1000));
    p++;
    for (int t = 0; t < NUM_TX; t++) begin
      mem[p]   = mk(OP_WR, XFER_REG, CMD_START);
      mem[p+1] = mk(OP_WAIT, XFER_REG, STAT_IDLE);
      p += 2;
      for (int b = 0; b < tx_len(t); b++) begin
        mem[p]   = mk(OP_WR, XFER_REG, CMD_WRITE | {8'h00, tx_byte(t, b)});
        mem[p+1] = mk(OP_WAIT, XFER_REG, STAT_IDLE);
        p += 2;
      end
      mem[p]   = mk(OP_WR, XFER_REG, CMD_STOP);
      mem[p+1] = mk(OP_WAIT, XFER_REG, STAT_IDLE);
      p += 2;
    end
    mem[p] = mk(OP_END, '0, '0);
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              srst,
  output logic [AW-1:0]     pc,
  input  instr_t            instr,
  output logic [REG_AW-1:0] bus_addr,
  output logic [REG_DW-1:0] bus_wdata,
  output logic              bus_we,
  input  logic [REG_DW-1:0] bus_rdata,
  output logic              done
);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_POLL, S_DONE} st_e;

  st_e               state;
  logic [REG_DW-1:0] expect_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      state     <= S_FETCH;
      pc        <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      expect_q  <= '0;
      done      <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      case (state)
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          case (instr.op)
            OP_WR: begin
              bus_addr  <= instr.addr;
              bus_wdata <= instr.data;
              bus_we    <= 1'b1;
              pc        <= pc + 1'b1;
              state     <= S_FETCH;
            end
            OP_WAIT: begin
              bus_addr <= instr.addr;
              expect_q <= instr.data;
              state    <= S_POLL;
            end
            default: begin
              done  <= 1'b1;
              state <= S_DONE;
            end
          endcase
        end
        S_POLL: begin
          if (bus_rdata == expect_q) begin
            pc    <= pc + 1'b1;
            state <= S_FETCH;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_init_seq.sv
module i2c_init_seq
  import i2c_seq_pkg::*;
#(
  parameter int          CLK_HZ   = 50_000_000,
  parameter logic [6:0]  SW_ADDR  = 7'h70,
  parameter int          SW_CH    = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int          NUM_DIV  = 2,
  parameter logic [NUM_DIV*24-1:0] DIV_VALS = {24'h00F3E4, 24'h0A1B2C},
  parameter logic [7:0]  DIV_BASE = 8'h20,
  parameter logic [7:0]  LOCK_REG = 8'h60,
  parameter logic [7:0]  LOCK_VAL = 8'h01,
  parameter logic [7:0]  CAL_REG  = 8'h61,
  parameter logic [7:0]  CAL_VAL  = 8'h40,
  localparam int PROG_LEN = 1 + 8 + (NUM_DIV * 3 + 2) * 10 + 1,
  localparam int AW       = $clog2(PROG_LEN)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dev_not_ready,
  output logic [1:0]  bus_addr,
  output logic [15:0] bus_wdata,
  output logic        bus_we,
  input  logic [15:0] bus_rdata,
  output logic        done
);

  logic          srst;
  logic [AW-1:0] pc;
  instr_t        instr;

  assign srst = rst | dev_not_ready;

  i2c_seq_rom #(
    .CLK_HZ(CLK_HZ), .SW_ADDR(SW_ADDR), .SW_CH(SW_CH), .DEV_ADDR(DEV_ADDR),
    .NUM_DIV(NUM_DIV), .DIV_VALS(DIV_VALS), .DIV_BASE(DIV_BASE),
    .LOCK_REG(LOCK_REG), .LOCK_VAL(LOCK_VAL), .CAL_REG(CAL_REG), .CAL_VAL(CAL_VAL)
  ) u_rom (
    .clk     (clk),
    .rd_addr (pc),
    .rd_data (instr)
  );

  i2c_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .srst      (srst),
    .pc        (pc),
    .instr     (instr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .done      (done)
  );

endmodule

// File: rtl/i2c_init_seq_chk.sv
module i2c_init_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       dev_not_ready,
  input logic [1:0] bus_addr,
  input logic       bus_we,
  input logic       done
);

  // R8: strobe lasts a single cycle
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (rst || dev_not_ready)
    bus_we |=> !bus_we);

  // R9: done holds until reset or hold
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst || dev_not_ready)
    done |=> done);

  // R9: no writes once finished
  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rst || dev_not_ready)
    done |-> !bus_we);

  // R1: hold flag keeps the bus and done low
  assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    dev_not_ready |=> (!bus_we && !done));

  // R3: writes only target the two master registers
  assert_reg_range_R3: assert property (@(posedge clk) disable iff (rst || dev_not_ready)
    bus_we |-> (bus_addr <= 2'd1));

endmodule

bind i2c_init_seq i2c_init_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .dev_not_ready (dev_not_ready),
  .bus_addr      (bus_addr),
  .bus_we        (bus_we),
  .done          (done)
);

// File: tb/i2c_init_seq_bench.sv
module i2c_init_seq_bench;

  localparam int N_WR = 45;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_not_ready = 1'b1;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_we;
  logic [15:0] bus_rdata;
  logic        done;

  always #10 clk = ~clk;

  i2c_init_seq u_i2c_init_seq (
    .clk(clk), .rst(rst), .dev_not_ready(dev_not_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .done(done)
  );

  int tests = 0;
  int fails = 0;

  // master model: busy for lat cycles after any transfer command
  int lat = 0;
  int busy = 0;
  always @(posedge clk) begin
    if (bus_we && bus_addr == 2'd1) busy <= lat;
    else if (busy > 0) busy <= busy - 1;
  end
  assign bus_rdata = (busy == 0) ? 16'h0001 : 16'h0000;

  // expected write stream
  logic [1:0]  exp_a [N_WR];
  logic [15:0] exp_d [N_WR];
  initial begin
    int k;
    logic [23:0] dv [2];
    dv[0] = 24'h0A1B2C;
    dv[1] = 24'h00F3E4;
    k = 0;
    exp_a[k] = 2'd0; exp_d[k] = 16'(50_000_000 / 1000); k++;
    exp_a[k] = 2'd1; exp_d[k] = 16'h0200; k++;
    exp_a[k] = 2'd1; exp_d[k] = 16'h0100 | 16'(8'h70 << 1); k++;
    exp_a[k] = 2'd1; exp_d[k] = 16'h0100 | 16'(1 << 7); k++;
    exp_a[k] = 2'd1; exp_d[k] = 16'h0400; k++;
    for (int e = 0; e < 8; e++) begin
      logic [7:0] idx, val;
      if (e < 6) begin
        idx = 8'h20 + 8'(e);
        val = 8'((dv[e / 3] >> (8 * (2 - e % 3))) & 24'hFF);
      end else if (e == 6) begin
        idx = 8'h60; val = 8'h01;
      end else begin
        idx = 8'h61; val = 8'h40;
      end
      exp_a[k] = 2'd1; exp_d[k] = 16'h0200; k++;
      exp_a[k] = 2'd1; exp_d[k] = 16'h0100 | 16'(8'h69 << 1); k++;
      exp_a[k] = 2'd1; exp_d[k] = 16'h0100 | {8'h00, idx}; k++;
      exp_a[k] = 2'd1; exp_d[k] = 16'h0100 | {8'h00, val}; k++;
      exp_a[k] = 2'd1; exp_d[k] = 16'h0400; k++;
    end
  end

  function automatic string tag_of(int i);
    if (i == 0)       return "R2";
    else if (i < 5)   return "R4";
    else if (i >= 35) return "R6";
    else              return "R5";
  endfunction

  // write monitor
  int  idx = 0;
  int  hold_writes = 0;
  logic prev_we = 1'b0;
  logic done_seen = 1'b0;
  always @(negedge clk) begin
    if (rst || dev_not_ready) begin
      if (bus_we) hold_writes++;
      idx = 0;
      done_seen = 1'b0;
    end else begin
      if (bus_we) begin
        tests++;
        if (prev_we) begin
          fails++; $display("FAIL R8 strobe longer than one cycle: got 1 expected 0");
        end
        if (done_seen) begin
          fails++; $display("FAIL R9 write after done: got addr %0d expected none", bus_addr);
        end
        if (bus_addr == 2'd1 && busy != 0 && idx > 1) begin
          fails++; $display("FAIL R7 command while busy: got busy %0d expected 0", busy);
        end
        if (idx >= N_WR) begin
          fails++; $display("FAIL R9 extra write %0d: got %h expected none", idx, bus_wdata);
        end else if (bus_addr !== exp_a[idx] || bus_wdata !== exp_d[idx]) begin
          fails++;
          $display("FAIL %s/R3 write %0d: got %0d:%h expected %0d:%h", tag_of(idx), idx,
                   bus_addr, bus_wdata, exp_a[idx], exp_d[idx]);
        end
        idx++;
      end
      if (done && !done_seen) begin
        done_seen = 1'b1;
        tests++;
        if (idx != N_WR) begin
          fails++; $display("FAIL R9 done after %0d writes: got %0d expected %0d", idx, idx, N_WR);
        end
      end
    end
    prev_we = bus_we;
  end

  task automatic check(input bit ok, input string msg, input int got, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", msg, got, expv);
    end
  endtask

  task automatic wait_done(input int limit, input string tag);
    int n = 0;
    while (!done && n < limit) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, tag, int'(done), 1);
  endtask

  task automatic full_run(input int l);
    lat = l;
    @(negedge clk);
    dev_not_ready = 1'b1;
    repeat (6) @(negedge clk);
    check(bus_we === 1'b0 && done === 1'b0, "R1 hold keeps outputs low", int'(done), 0);
    dev_not_ready = 1'b0;
    wait_done(20000, "R7 program completes with polling");
    check(idx == N_WR, "R9 write count at done", idx, N_WR);
    repeat (40) @(negedge clk);
    check(done === 1'b1 && idx == N_WR, "R9 done sticky and quiet", idx, N_WR);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_we === 1'b0 && done === 1'b0, "R1 reset state", int'(bus_we), 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(hold_writes == 0 && done === 1'b0, "R1 no writes while not ready", hold_writes, 0);

    full_run(0);
    full_run(3);
    full_run(17);

    // R10: abort mid-program and replay from the start
    lat = 2;
    @(negedge clk);
    dev_not_ready = 1'b1;
    repeat (3) @(negedge clk);
    dev_not_ready = 1'b0;
    while (idx < 12) @(negedge clk);
    dev_not_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(idx == 0 && done === 1'b0, "R10 abort clears progress", idx, 0);
    dev_not_ready = 1'b0;
    wait_done(20000, "R10 replay completes");
    check(idx == N_WR, "R10 full stream replayed", idx, N_WR);

    // R1: synchronous reset also returns to step zero
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && bus_we === 1'b0, "R1 reset clears done", int'(done), 0);
    rst = 1'b0;
    wait_done(20000, "R1 restart after reset");
    check(hold_writes == 0, "R1 no writes during hold windows", hold_writes, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule